// File: doc/BRIEF.md
# Transceiver power-up reset sequencer

This block drives the four reset lines of one serial transceiver channel from power-up until the channel can enter its link initialization and compliance phase. It first holds the PLL analog reset for a fixed number of clock cycles. Throughout that time it also holds the transmit digital, receive analog and receive digital resets. It then releases the PLL and waits for the PLL lock indication. When lock is seen, it releases the transmit digital reset. It then waits for the reconfiguration busy flag to go low and counts a short settle window. At the end of that window it releases both receive resets on the same clock edge.

The block has no receiver frequency-lock input. In this phase the receive resets are released by timing alone, counted after busy falls, and never by the clock-data-recovery lock. If PLL lock is lost before the sequence finishes, the full sequence starts again from the PLL hold. When every reset has been released, a one-cycle done pulse hands control to the logic for the normal operating phase. After that, the block stays in its released state until the next global reset. The PLL hold time and the settle window are parameters counted in clock cycles. The PLL, the CDR and the link-layer logic lie outside the block.

Top module: `xcvr_rst_seq`

## Requirements
- R1: After a clock edge with `rst_n` low, `pll_rst` stays high through the first HOLD_CYC-1 rising edges with `rst_n` high and goes low after edge number HOLD_CYC.
- R2: While `pll_rst` is high, `tx_drst`, `rx_arst` and `rx_drst` are all high.
- R3: `tx_drst` goes low after the first edge, later than the edge that releases `pll_rst`, at which `pll_lock` is sampled high. A lock seen during the PLL hold has no effect.
- R4: Once `tx_drst` is low, the receive resets go low POST_CYC edges after the first edge at which `cfg_busy` is sampled low.
- R5: `rx_arst` and `rx_drst` always change on the same clock edge.
- R6: If `cfg_busy` is sampled high during the settle window, the window is abandoned. A full POST_CYC-edge window restarts from the next edge at which busy is low.
- R7: If `pll_lock` is sampled low while `tx_drst` is low and the receive resets are still high, `pll_rst` goes high after that edge and the whole sequence restarts with a full HOLD_CYC hold. Once the receive resets are released, a loss of lock has no effect.
- R8: `seq_done` is high for exactly one cycle, in the same cycle that the receive resets first go low.
- R9: The reset is synchronous and active low. After an edge with `rst_n` low, all four reset outputs are high and `seq_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low global reset |
| pll_lock | input | 1 | PLL lock indication, synchronous to clk |
| cfg_busy | input | 1 | Reconfiguration busy flag, synchronous to clk |
| pll_rst | output | 1 | PLL analog reset, active high |
| tx_drst | output | 1 | Transmit digital reset, active high |
| rx_arst | output | 1 | Receive analog reset, active high |
| rx_drst | output | 1 | Receive digital reset, active high |
| seq_done | output | 1 | One-cycle pulse when every reset is released |

## Verification
The bench uses a small configuration (a hold of five cycles and a settle window of two). It sweeps the edge at which lock rises against the edge at which busy falls. Lock arriving before, at, or after the end of the hold separates a lock that is ignored during the hold from one that releases the transmit reset. Busy falling before or after the transmit release separates a busy that is already low from a wait on busy. A one-edge busy pulse inside the settle window shows that the window restarts and does not carry on. Lock drops at every edge between the transmit release and the receive release show that the full sequence restarts. Lock drops just after completion show that the released state holds.

// File: rtl/xrs_pkg.sv
// Shared types for the transceiver reset sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package xrs_pkg;

    // Sequencer phases in the order they are normally visited.
    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,   // PLL analog reset held
        ST_WLOCK  = 3'd1,   // PLL released, waiting for lock
        ST_WBUSY  = 3'd2,   // TX released, waiting for busy low
        ST_SETTLE = 3'd3,   // counting the settle window after busy
        ST_RUN    = 3'd4    // every reset released
    } xrs_state_t;

endpackage

// File: rtl/xrs_timer.sv
// Down-counter used for the PLL hold and the post-busy settle window.
// Loads on request, then counts down to zero and stays there.
// Assumes RST_VAL fits in W bits.
module xrs_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Count register: reset/load value, else decrement to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Terminal-count flag.
    assign zero = (cnt_q == '0);

endmodule

// File: rtl/xrs_fsm.sv
// Sequencing state machine. Decides the next phase from lock, busy and
// the timer, and reloads the timer whenever it enters a counted phase.
// Assumes lock and busy are already synchronous to clk, HOLD_CYC >= 1
// and POST_CYC >= 1.
module xrs_fsm
    import xrs_pkg::*;
#(
    parameter int W        = 8,
    parameter int HOLD_CYC = 125,
    parameter int POST_CYC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lock,
    input  logic         busy,
    input  logic         tmr_zero,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val,
    output xrs_state_t   state_q,
    output xrs_state_t   state_d
);

    localparam logic [W-1:0] HOLD_LD = W'(HOLD_CYC - 1);
    localparam logic [W-1:0] POST_LD = W'(POST_CYC - 1);

    // Next-phase and timer-reload decision.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = HOLD_LD;
        unique case (state_q)
            ST_HOLD: begin
                if (tmr_zero) state_d = ST_WLOCK;
            end
            ST_WLOCK: begin
                if (lock) state_d = ST_WBUSY;
            end
            ST_WBUSY: begin
                if (!lock) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                end else if (!busy) begin
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = POST_LD;
                end
            end
            ST_SETTLE: begin
                if (!lock) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                end else if (busy) begin
                    state_d  = ST_WBUSY;
                end else if (tmr_zero) begin
                    state_d  = ST_RUN;
                end
            end
            ST_RUN:  state_d = ST_RUN;
            default: begin
                state_d  = ST_HOLD;
                tmr_load = 1'b1;
            end
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/xrs_outreg.sv
// Output register stage. Decodes the next phase so that every output
// is a flop aligned with the phase register.
// Assumes state_q and state_d come from the same sequencing FSM.
module xrs_outreg
    import xrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  xrs_state_t state_q,
    input  xrs_state_t state_d,
    output logic       pll_rst,
    output logic       tx_drst,
    output logic       rx_arst,
    output logic       rx_drst,
    output logic       seq_done
);

    // Registered decode of the four resets and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_rst  <= 1'b1;
            tx_drst  <= 1'b1;
            rx_arst  <= 1'b1;
            rx_drst  <= 1'b1;
            seq_done <= 1'b0;
        end else begin
            pll_rst  <= (state_d == ST_HOLD);
            tx_drst  <= (state_d == ST_HOLD) || (state_d == ST_WLOCK);
            rx_arst  <= (state_d != ST_RUN);
            rx_drst  <= (state_d != ST_RUN);
            seq_done <= (state_d == ST_RUN) && (state_q != ST_RUN);
        end
    end

endmodule

// File: rtl/xcvr_rst_seq.sv
// Transceiver power-up reset sequencer top. Holds the PLL reset for
// HOLD_CYC cycles, releases TX on PLL lock, then releases both RX
// resets together POST_CYC cycles after busy falls.
// Assumes pll_lock and cfg_busy are synchronous to clk.
module xcvr_rst_seq
    import xrs_pkg::*;
#(
    parameter int HOLD_CYC = 125,
    parameter int POST_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_lock,
    input  logic cfg_busy,
    output logic pll_rst,
    output logic tx_drst,
    output logic rx_arst,
    output logic rx_drst,
    output logic seq_done
);

    localparam int MAXC = (HOLD_CYC > POST_CYC) ? HOLD_CYC : POST_CYC;
    localparam int CW   = $clog2(MAXC + 1) + 1;

    logic          tmr_load;
    logic          tmr_zero;
    logic [CW-1:0] tmr_val;
    xrs_state_t    st_q;
    xrs_state_t    st_d;

    xrs_timer #(
        .W       (CW),
        .RST_VAL (HOLD_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    xrs_fsm #(
        .W        (CW),
        .HOLD_CYC (HOLD_CYC),
        .POST_CYC (POST_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock     (pll_lock),
        .busy     (cfg_busy),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .state_q  (st_q),
        .state_d  (st_d)
    );

    xrs_outreg u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_q  (st_q),
        .state_d  (st_d),
        .pll_rst  (pll_rst),
        .tx_drst  (tx_drst),
        .rx_arst  (rx_arst),
        .rx_drst  (rx_drst),
        .seq_done (seq_done)
    );

endmodule

// File: rtl/xrs_chk.sv
// Protocol checker for the reset sequencer, bound to the top module.
// Observes ports only.
module xrs_chk (
    input logic clk,
    input logic rst_n,
    input logic pll_lock,
    input logic cfg_busy,
    input logic pll_rst,
    input logic tx_drst,
    input logic rx_arst,
    input logic rx_drst,
    input logic seq_done
);

    // R2: the PLL hold keeps every other reset asserted
    p_hold_covers_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |-> (tx_drst && rx_arst && rx_drst));

    // R3: TX leaves reset only after lock was seen with the PLL running
    p_tx_on_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_drst) |-> ($past(pll_lock) && !$past(pll_rst)));

    // R4: RX release follows a cycle with busy low and lock present
    p_rx_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_arst) |-> (!$past(cfg_busy) && $past(pll_lock)));

    // R5: both receive resets fall together
    p_rx_fall_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_arst) |-> $fell(rx_drst));

    // R5: both receive resets rise together
    p_rx_rise_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_drst) |-> $rose(rx_arst));

    // R7: loss of lock mid-sequence returns to the PLL hold
    p_lock_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_drst && rx_arst && !pll_lock) |=> pll_rst);

    // R8: done lasts a single cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    // R8: done coincides with the receive release
    p_done_at_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_arst) |-> seq_done);

    // R9: a reset edge leaves every reset output asserted
    p_sync_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (pll_rst && tx_drst && rx_arst && rx_drst && !seq_done));

endmodule

bind xcvr_rst_seq xrs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pll_lock (pll_lock),
    .cfg_busy (cfg_busy),
    .pll_rst  (pll_rst),
    .tx_drst  (tx_drst),
    .rx_arst  (rx_arst),
    .rx_drst  (rx_drst),
    .seq_done (seq_done)
);

// File: tb/sim_xcvr_rst_seq.sv
`timescale 1ns/1ps
module sim_xcvr_rst_seq;

    localparam int HOLD = 5;
    localparam int POST = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pll_lock = 1'b0;
    logic cfg_busy = 1'b1;
    logic pll_rst, tx_drst, rx_arst, rx_drst, seq_done;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    xcvr_rst_seq #(.HOLD_CYC(HOLD), .POST_CYC(POST)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .pll_lock (pll_lock),
        .cfg_busy (cfg_busy),
        .pll_rst  (pll_rst),
        .tx_drst  (tx_drst),
        .rx_arst  (rx_arst),
        .rx_drst  (rx_drst),
        .seq_done (seq_done)
    );

    always #4 clk = ~clk;

    task automatic chk(input logic act, input logic exp, input string tag, input int k);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at edge %0d: actual=%b expected=%b", tag, k, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // One sequence: la = first edge with lock high, bd = first edge with busy
    // low, d = edge where lock drops mid-sequence (0: none), g = busy pulse
    // one edge into the settle window.
    task automatic run_case(input int la, input int bd, input int d, input bit g);
        int t, t2, m, r, gk;
        t  = imax(la, HOLD + 1);
        t2 = 0;
        gk = -1;
        if (d > 0) begin
            t2 = d + HOLD + 1;
            m  = imax(bd, t2 + 1);
            r  = m + POST;
        end else begin
            m  = imax(bd, t + 1);
            r  = g ? (m + 2 + POST) : (m + POST);
            if (g) gk = m + 1;
        end
        // R9: reset from whatever state the last case left
        @(negedge clk);
        rst_n = 1'b0; pll_lock = 1'b0; cfg_busy = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk(pll_rst,  1'b1, "R9 pll_rst", 0);
        chk(tx_drst,  1'b1, "R9 tx_drst", 0);
        chk(rx_arst,  1'b1, "R9 rx_arst", 0);
        chk(rx_drst,  1'b1, "R9 rx_drst", 0);
        chk(seq_done, 1'b0, "R9 seq_done", 0);
        for (int k = 1; k <= r + 4; k++) begin
            bit e_pll, e_tx, e_rx, e_done;
            rst_n    = 1'b1;
            // lock also drops just after completion (R7: must be ignored)
            pll_lock = (k >= la) && (k != d) && (k != r + 1) && (k != r + 2);
            cfg_busy = (k < bd) || (k == gk);
            @(posedge clk);
            @(negedge clk);
            e_pll  = (k < HOLD) || (d > 0 && k >= d && k < d + HOLD);
            e_tx   = (k < t) || (d > 0 && k >= d && k < t2);
            e_rx   = (k < r);
            e_done = (k == r);
            chk(pll_rst, e_pll, (d > 0) ? "R7 pll_rst restart" : "R1 pll_rst hold", k);
            chk(tx_drst, e_tx, "R3 tx_drst", k);
            chk(rx_arst, e_rx, g ? "R6 rx_arst restart" : "R4 rx_arst", k);
            chk(rx_drst, rx_arst, "R5 rx_drst pairs rx_arst", k);
            chk(seq_done, e_done, "R8 seq_done", k);
            if (pll_rst)
                chk(tx_drst & rx_arst & rx_drst, 1'b1, "R2 all held", k);
        end
    endtask

    initial begin
        // R1/R3/R4/R5/R8: sweep lock arrival against busy release
        for (int la = 0; la <= 8; la++)
            for (int bd = 0; bd <= 12; bd++)
                for (int g = 0; g <= 1; g++)
                    run_case(la, bd, 0, g[0]);
        // R7: lock loss at every edge between TX and RX release
        for (int la = 0; la <= 2; la++) begin
            int t0, r0;
            t0 = HOLD + 1;
            r0 = imax(9, t0 + 1) + POST;
            for (int d = t0 + 1; d <= r0; d++)
                run_case(la, 9, d, 1'b0);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (R1..R9 run) actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule